// File: doc/BRIEF.md
# Half-bridge dead-time and interlock controller

This block sits between a PWM controller and the two gate drivers of one inverter half-bridge. It receives a low-side command and an active-low high-side command, so a single PWM wire tied to both inputs gives complementary switching. It drives registered high-side and low-side gate enables, never both at once. Every turn-on waits out a programmable dead time counted in clock cycles, and turn-off carries no added delay. Three instances form a six-switch bridge.

All inputs are asynchronous and pass through a two-stage synchronizer. A command that asks for both switches at the same time is refused. The outputs then keep their previous state, and a one-cycle flag reports the refusal. The dead time is counted from the moment the conducting switch turns off. Input edges that fall inside one dead time therefore give the same result as one simultaneous change. A command shorter than the dead time turns the old switch off, but the new switch never comes on. A global disable input forces both gates off.

Top module: `hb_interlock`

## Requirements
- R1: A low level on `hi_cmd_n` requests the high side and a high level on `lo_cmd` requests the low side. With one PWM line tied to both inputs, a high line selects the low-side gate and a low line selects the high-side gate.
- R2: When the request for a conducting switch goes away, its gate output drops 3 clock edges after the input change: 2 synchronizer stages plus the output register. No dead time is added.
- R3: The gates start idle, with both off for longer than the dead time. When a single request then arrives, its gate turns on DT clock edges after the edge on which its gate would have turned off, which is 3+DT edges after the input change. DT is the dead-time setting in force.
- R4: The dead time is the same whether the switch that turns on is the high side or the low side.
- R5: While both switches are requested, both gate outputs keep the values they had before.
- R6: The opposite switch may be requested within the dead time after the conducting switch turned off. It then turns on in the same cycle as it would have after a simultaneous change on both inputs.
- R7: A request for the other switch may last fewer cycles than the dead time before the original request returns. The conducting switch still turns off, the other switch stays off throughout, and the original switch turns back on one dead time after its turn-off.
- R8: `dt_cfg` is taken into the dead-time register only while both gates are off. A change made while a gate conducts does not alter the dead time of the switch-over that follows, and the new value applies after the next idle period.
- R9: A `dt_cfg` value below MIN_DT (default 1) is treated as MIN_DT, so a setting of 0 gives a one-cycle dead time.
- R10: `bridge_off` high forces both gates low 3 edges after it rises. After it is released, a turn-on waits the full dead time, as in R3.
- R11: `conflict` is high for exactly one cycle, 3 edges after a both-switches request first appears, and stays low while that request persists.
- R12: During reset both gates and `conflict` are low.
- R13: The high-side and low-side gate outputs are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bridge_off | input | 1 | Global disable, forces both gates off |
| lo_cmd | input | 1 | Low-side request, active high, asynchronous |
| hi_cmd_n | input | 1 | High-side request, active low, asynchronous |
| dt_cfg | input | 6 | Dead-time setting in clock cycles |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |
| conflict | output | 1 | One-cycle pulse on a refused both-switches request |

## Verification
The assertions watch the cycle-level invariants on every clock. The two gates are never on together. A switch whose synchronized request is gone drops on the next edge. A synchronized both-switches request leaves the gates unchanged. The conflict flag is a single-cycle pulse that follows such a request. Every turn-on comes after at least the minimum number of both-off cycles, and a disable held for three cycles clears both gates. The bench scenarios supply the rest. They show the exact turn-on cycle for each dead-time setting, including the merging of staggered edges and the swallowing of short pulses. They also show that a `dt_cfg` change made while a gate conducts is ignored until the next idle period.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
    // Width of the dead-time counter and setting.
    localparam int DT_W = 6;

    typedef logic [DT_W-1:0] dt_t;

    // Registered state of the interlock core.
    typedef struct packed {
        logic gh;      // high-side gate enable
        logic gl;      // low-side gate enable
        dt_t  cnt;     // remaining dead-time cycles, 0 = expired
        logic both_q;  // both requested in previous cycle
        logic conf;    // conflict pulse
    } core_st_t;

    function automatic dt_t clamp_dt(dt_t cfg, int unsigned min_dt);
        dt_t lo;
        lo = dt_t'(min_dt);
        return (cfg < lo) ? lo : cfg;
    endfunction
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d_in;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_q[g] <= '0;
            end else begin
                stg_q[g] <= stg_d[g];
            end
        end
    end

    assign d_out = stg_q[STAGES-1];
endmodule

// File: rtl/hbi_dtsel.sv
module hbi_dtsel
    import hbi_pkg::*;
#(
    parameter int MIN_DT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  dt_t  dt_cfg,
    input  logic idle,     // both gates off
    output dt_t  dt_val
);
    dt_t dt_d, dt_q;

    always_comb begin
        dt_d = dt_q;
        if (idle) begin
            dt_d = clamp_dt(dt_cfg, MIN_DT);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dt_q <= dt_t'(MIN_DT);
        end else begin
            dt_q <= dt_d;
        end
    end

    assign dt_val = dt_q;
endmodule

// File: rtl/hbi_core.sv
module hbi_core
    import hbi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_hi,
    input  logic req_lo,
    input  logic off,
    input  dt_t  dt_val,
    output logic gh,
    output logic gl,
    output logic conf
);
    core_st_t st_d, st_q;
    logic     both;

    always_comb begin
        both      = req_hi && req_lo;
        st_d      = st_q;
        st_d.conf = 1'b0;
        st_d.both_q = both;
        if (off) begin
            st_d.gh  = 1'b0;
            st_d.gl  = 1'b0;
            st_d.cnt = '0;
        end else if (both) begin
            // refuse: hold gates and timer, flag first cycle only
            st_d.conf = !st_q.both_q;
        end else if (st_q.gh && !req_hi) begin
            st_d.gh  = 1'b0;
            st_d.cnt = dt_val;
        end else if (st_q.gl && !req_lo) begin
            st_d.gl  = 1'b0;
            st_d.cnt = dt_val;
        end else if (!st_q.gh && !st_q.gl) begin
            if (st_q.cnt == '0) begin
                if (req_hi || req_lo) begin
                    st_d.cnt = dt_val;
                end
            end else if (st_q.cnt == dt_t'(1)) begin
                st_d.cnt = '0;
                if (req_hi) begin
                    st_d.gh = 1'b1;
                end else if (req_lo) begin
                    st_d.gl = 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt - dt_t'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gh   = st_q.gh;
    assign gl   = st_q.gl;
    assign conf = st_q.conf;
endmodule

// File: rtl/hb_interlock.sv
module hb_interlock
    import hbi_pkg::*;
#(
    parameter int MIN_DT      = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bridge_off,
    input  logic            lo_cmd,
    input  logic            hi_cmd_n,
    input  logic [DT_W-1:0] dt_cfg,
    output logic            gate_hi,
    output logic            gate_lo,
    output logic            conflict
);
    localparam int N_SYNC = 3;

    logic [N_SYNC-1:0] raw_in, sync_out;
    logic req_hi_s, req_lo_s, dis_s;
    dt_t  dt_val;

    // invert before the synchronizer so a reset value of 0 means no request
    assign raw_in = {bridge_off, lo_cmd, ~hi_cmd_n};

    hbi_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_in),
        .d_out (sync_out)
    );

    assign {dis_s, req_lo_s, req_hi_s} = sync_out;

    hbi_dtsel #(.MIN_DT(MIN_DT)) i_dtsel (
        .clk    (clk),
        .rst_n  (rst_n),
        .dt_cfg (dt_cfg),
        .idle   (!gate_hi && !gate_lo),
        .dt_val (dt_val)
    );

    hbi_core i_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_hi (req_hi_s),
        .req_lo (req_lo_s),
        .off    (dis_s),
        .dt_val (dt_val),
        .gh     (gate_hi),
        .gl     (gate_lo),
        .conf   (conflict)
    );
endmodule

// File: rtl/hbi_checker.sv
module hbi_checker #(
    parameter int MIN_DT = 1
) (
    input logic clk,
    input logic rst_n,
    input logic bridge_off,
    input logic req_hi_s,
    input logic req_lo_s,
    input logic dis_s,
    input logic gate_hi,
    input logic gate_lo,
    input logic conflict
);
    logic [7:0] off_run;
    logic [1:0] dis_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_run <= '0;
            dis_run <= '0;
        end else begin
            if (gate_hi || gate_lo) begin
                off_run <= '0;
            end else if (off_run != 8'hff) begin
                off_run <= off_run + 8'd1;
            end
            if (!bridge_off) begin
                dis_run <= '0;
            end else if (dis_run != 2'd3) begin
                dis_run <= dis_run + 2'd1;
            end
        end
    end

    p_never_both_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo));

    p_hi_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi && !req_hi_s) |=> !gate_hi);

    p_lo_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_lo && !req_lo_s) |=> !gate_lo);

    p_hold_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_hi_s && req_lo_s && !dis_s) |=> ($stable(gate_hi) && $stable(gate_lo)));

    p_conf_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |=> !conflict);

    p_conf_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> $past(req_hi_s && req_lo_s));

    p_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_hi) || $rose(gate_lo)) |-> (off_run >= 8'(MIN_DT)));

    p_disable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_run == 2'd3 && bridge_off) |=> (!gate_hi && !gate_lo));
endmodule

bind hb_interlock hbi_checker #(.MIN_DT(MIN_DT)) i_hbi_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bridge_off (bridge_off),
    .req_hi_s   (req_hi_s),
    .req_lo_s   (req_lo_s),
    .dis_s      (dis_s),
    .gate_hi    (gate_hi),
    .gate_lo    (gate_lo),
    .conflict   (conflict)
);

// File: tb/test_hb_interlock.sv
module test_hb_interlock;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bridge_off = 1'b0;
    logic       lo_cmd = 1'b0;
    logic       hi_cmd_n = 1'b1;
    logic [5:0] dt_cfg = 6'd4;
    logic       gate_hi, gate_lo, conflict;

    int n_chk  = 0;
    int n_fail = 0;
    int n_overlap = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hb_interlock i_hb_interlock (
        .clk        (clk),
        .rst_n      (rst_n),
        .bridge_off (bridge_off),
        .lo_cmd     (lo_cmd),
        .hi_cmd_n   (hi_cmd_n),
        .dt_cfg     (dt_cfg),
        .gate_hi    (gate_hi),
        .gate_lo    (gate_lo),
        .conflict   (conflict)
    );

    // bits: lo_cmd, hi_cmd_n, bridge_off, expected gate_hi, expected gate_lo
    localparam int NV = 12;
    localparam logic [4:0] VEC [NV] = '{
        5'b01000,  // R1 none
        5'b11001,  // R1 low side
        5'b00010,  // R1 high side
        5'b10010,  // R5 both: keep high side
        5'b01000,  // none
        5'b10000,  // R5 both from idle: keep off
        5'b11001,  // low side again
        5'b10001,  // R5 both: keep low side
        5'b11100,  // R10 disabled
        5'b11001,  // R10 released
        5'b00010,  // R1 tied line low
        5'b00100   // R10 disabled
    };

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(logic lo, logic hin, logic dis);
        lo_cmd     = lo;
        hi_cmd_n   = hin;
        bridge_off = dis;
    endtask

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic go_idle();
        drive(1'b0, 1'b1, 1'b0);
        step(14);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            chk("R13 gates never on together", n_overlap == 0, 1'b1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(negedge clk) begin
        if (gate_hi && gate_lo) n_overlap++;
    end

    initial begin
        #(5ns * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic seen;
        // R12: reset state while a request is applied
        drive(1'b1, 1'b0, 1'b0);
        step(4);
        chk("R12 gate_hi in reset", gate_hi, 1'b0);
        chk("R12 gate_lo in reset", gate_lo, 1'b0);
        chk("R12 conflict in reset", conflict, 1'b0);
        drive(1'b0, 1'b1, 1'b0);
        step(1);
        rst_n = 1'b1;
        step(14);

        // vector table, settled outputs
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][4], VEC[i][3], VEC[i][2]);
            step(12);
            chk($sformatf("R1/R5/R10 vector %0d gate_hi", i), gate_hi, VEC[i][1]);
            chk($sformatf("R1/R5/R10 vector %0d gate_lo", i), gate_lo, VEC[i][0]);
        end

        // R3: turn-on from idle with dead time 4
        go_idle();
        drive(1'b1, 1'b1, 1'b0);
        step(6);
        chk("R3 low side still off", gate_lo, 1'b0);
        step(1);
        chk("R3 low side on after dead time", gate_lo, 1'b1);

        // R2 and R4: tied line switches to high side
        drive(1'b0, 1'b0, 1'b0);
        step(2);
        chk("R2 low side before turn-off", gate_lo, 1'b1);
        step(1);
        chk("R2 low side off after 3 edges", gate_lo, 1'b0);
        step(3);
        chk("R4 high side still off", gate_hi, 1'b0);
        step(1);
        chk("R4 high side on", gate_hi, 1'b1);
        drive(1'b1, 1'b1, 1'b0);
        step(3);
        chk("R2 high side off after 3 edges", gate_hi, 1'b0);
        step(3);
        chk("R4 low side still off", gate_lo, 1'b0);
        step(1);
        chk("R4 low side on", gate_lo, 1'b1);

        // R6: staggered edges merge into one change
        drive(1'b0, 1'b1, 1'b0);
        step(2);
        drive(1'b0, 1'b0, 1'b0);
        step(4);
        chk("R6 high side still off", gate_hi, 1'b0);
        step(1);
        chk("R6 high side on as if simultaneous", gate_hi, 1'b1);

        // R7: short low-side pulse
        drive(1'b1, 1'b1, 1'b0);
        step(2);
        drive(1'b0, 1'b0, 1'b0);
        step(1);
        chk("R7 high side turned off", gate_hi, 1'b0);
        seen = 1'b0;
        for (int k = 0; k < 11; k++) begin
            step(1);
            if (gate_lo) seen = 1'b1;
        end
        chk("R7 low side never on", seen, 1'b0);
        chk("R7 high side back on", gate_hi, 1'b1);

        // R11: conflict pulse
        go_idle();
        drive(1'b1, 1'b0, 1'b0);
        step(3);
        chk("R11 conflict pulse high", conflict, 1'b1);
        step(1);
        chk("R11 conflict pulse one cycle", conflict, 1'b0);
        step(4);
        chk("R11 conflict stays low", conflict, 1'b0);
        chk("R5 both off held", gate_hi | gate_lo, 1'b0);

        // R8: dead-time change while conducting
        go_idle();
        drive(1'b1, 1'b1, 1'b0);
        step(12);
        dt_cfg = 6'd10;
        drive(1'b0, 1'b0, 1'b0);
        step(6);
        chk("R8 old dead time, still off", gate_hi, 1'b0);
        step(1);
        chk("R8 old dead time, on", gate_hi, 1'b1);
        go_idle();
        drive(1'b1, 1'b1, 1'b0);
        step(12);
        chk("R8 new dead time, still off", gate_lo, 1'b0);
        step(1);
        chk("R8 new dead time, on", gate_lo, 1'b1);

        // R9: zero setting clamps to minimum
        go_idle();
        dt_cfg = 6'd0;
        step(2);
        drive(1'b1, 1'b1, 1'b0);
        step(3);
        chk("R9 minimum dead time, still off", gate_lo, 1'b0);
        step(1);
        chk("R9 minimum dead time, on", gate_lo, 1'b1);
        dt_cfg = 6'd4;
        go_idle();

        // R10: disable timing and release
        drive(1'b1, 1'b1, 1'b0);
        step(12);
        drive(1'b1, 1'b1, 1'b1);
        step(2);
        chk("R10 before disable acts", gate_lo, 1'b1);
        step(1);
        chk("R10 disable forces off", gate_lo, 1'b0);
        step(4);
        drive(1'b1, 1'b1, 1'b0);
        step(6);
        chk("R10 release waits dead time", gate_lo, 1'b0);
        step(1);
        chk("R10 on after release", gate_lo, 1'b1);

        finish_run();
    end
endmodule